// File: doc/BRIEF.md
# Virtual Supervisor Top-Interrupt Selector

This block picks the one interrupt a guest supervisor should see first. It receives a small set of interrupt candidates that are already pending and enabled. Each candidate has a valid bit, a 6-bit identity and a priority number 9 bits wide. The block also receives the hypervisor's injection controls: an enable, an injected identity, an injected priority number, an ordering bit and a reporting-mode bit. It returns the identity of the winning candidate together with an 8-bit reported priority. Both outputs are zero when nothing is pending.

A smaller priority number is more urgent. Equal numbers are settled by a fixed identity ranking. The one exception is an injected candidate that is not the external interrupt: for it, the ordering bit alone decides whether it goes ahead of or behind the other candidates. A parameter selects either a purely combinational result or one output register stage.

Top module: `vsti_top`

## Requirements
- R1: Among valid candidates, the one with the smallest priority number is selected, and its identity appears on `top_id`.
- R2: When priority numbers are equal, identity 9 (external) ranks first and the other identities follow in ascending numeric order. If both identity and priority are equal, the injected entry goes ahead of list entries, and among list entries the lower index goes first.
- R3: When `inj_en`=1, `inj_id`≠9 and `inj_late`=0, the injected candidate wins over every list candidate that has the same priority number.
- R4: When `inj_en`=1, `inj_id`≠9 and `inj_late`=1, every list candidate with the same priority number wins over the injected candidate.
- R5: When `inj_en`=1 and `inj_id`=9, the injected candidate follows the R2 ranking and `inj_late` has no effect.
- R6: When `inj_en`=0, the injected fields have no effect on either output.
- R7: When no candidate is valid, `top_id` and `top_prio` are both 0.
- R8: When `prio_pass`=0 and a candidate exists, `top_prio` is 1.
- R9: When `prio_pass`=1 and the winning priority number is between 1 and 255, `top_prio` equals that number.
- R10: When `prio_pass`=1, a winning priority number above 255 reports 255 and a winning priority number of 0 reports 0.
- R11: With `OUT_REG`=1, the outputs show the result for the inputs of the previous clock edge and are 0 while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| cand_valid | input | N_CAND | One valid bit per list candidate |
| cand_id | input | N_CAND*ID_W | Packed candidate identities; entry i occupies bits [i*ID_W +: ID_W] |
| cand_prio | input | N_CAND*PRIO_W | Packed candidate priority numbers |
| inj_en | input | 1 | Enables the injected candidate |
| inj_id | input | ID_W | Identity of the injected candidate |
| inj_prio | input | PRIO_W | Priority number of the injected candidate |
| inj_late | input | 1 | Tie placement of a non-external injected candidate: 0 ahead, 1 behind |
| prio_pass | input | 1 | Reporting mode: 0 reports a constant 1, 1 passes the clamped priority number |
| top_id | output | ID_W | Identity of the winner, or 0 |
| top_prio | output | 8 | Reported priority of the winner, or 0 |

## Verification
The bench builds two copies with three list candidates, 6-bit identities and 9-bit priority numbers. One copy is combinational and the other has the output register, and both are driven by the same stimulus. Three candidates plus the injected entry are enough to cover every pairing of list and injected entries. Drawing priorities from a small set that includes 0, 1, 255, 256 and 511 produces frequent ties and reaches both clamp boundaries. Identities drawn from a set that includes 9, 0 and 63 test the ranking at its ends.

// File: rtl/vsti_pkg.sv
package vsti_pkg;

  // Width of the reported priority field.
  localparam int RPT_W = 8;

  // Reported priority from the winner's raw number and the reporting mode.
  function automatic logic [RPT_W-1:0] report_prio(input logic has_win,
                                                   input logic pass,
                                                   input logic [15:0] num);
    logic [RPT_W-1:0] r;
    if (!has_win)               r = '0;
    else if (!pass)             r = RPT_W'(1);
    else if (num > 16'd255)     r = '1;
    else                        r = num[RPT_W-1:0];
    return r;
  endfunction

endpackage

// File: rtl/vsti_key_gen.sv
module vsti_key_gen #(
  parameter int N_CAND = 4,
  parameter int ID_W   = 6,
  parameter int PRIO_W = 9,
  parameter int EXT_ID = 9,
  localparam int N_ENT = N_CAND + 1,
  localparam int ORD_W = ID_W + 1,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int KEY_W = PRIO_W + ORD_W + IDX_W
) (
  input  logic [N_CAND-1:0]        cand_valid,
  input  logic [N_CAND*ID_W-1:0]   cand_id,
  input  logic [N_CAND*PRIO_W-1:0] cand_prio,
  input  logic                     inj_en,
  input  logic [ID_W-1:0]          inj_id,
  input  logic [PRIO_W-1:0]        inj_prio,
  input  logic                     inj_late,
  output logic [N_ENT-1:0]         ent_valid,
  output logic [N_ENT*ID_W-1:0]    ent_id,
  output logic [N_ENT*KEY_W-1:0]   ent_key
);

  localparam logic [ID_W-1:0] EXT = ID_W'(EXT_ID);

  // Default rank: the external identity first, then ascending identity.
  // Entry slots are offset by one so that 0 and all-ones stay free for
  // a non-external injected entry.
  function automatic logic [ORD_W-1:0] list_ord(input logic [ID_W-1:0] id);
    logic [ORD_W-1:0] r;
    if (id == EXT) r = ORD_W'(1);
    else           r = ORD_W'(id) + ORD_W'(2);
    return r;
  endfunction

  // Entry 0: injected candidate.
  logic             inj_special;
  logic [ORD_W-1:0] inj_ord;
  assign inj_special = inj_en && (inj_id != EXT);
  assign inj_ord     = !inj_special ? list_ord(inj_id)
                     : (inj_late ? '1 : '0);

  assign ent_valid[0]          = inj_en;
  assign ent_id[0 +: ID_W]     = inj_id;
  assign ent_key[0 +: KEY_W]   = {inj_prio, inj_ord, IDX_W'(0)};

  // Entries 1..N_CAND: list candidates.
  for (genvar g = 0; g < N_CAND; g++) begin : g_list
    logic [ID_W-1:0]   id_g;
    logic [PRIO_W-1:0] pr_g;
    assign id_g = cand_id[g*ID_W +: ID_W];
    assign pr_g = cand_prio[g*PRIO_W +: PRIO_W];
    assign ent_valid[g+1]              = cand_valid[g];
    assign ent_id[(g+1)*ID_W +: ID_W]  = id_g;
    assign ent_key[(g+1)*KEY_W +: KEY_W] = {pr_g, list_ord(id_g), IDX_W'(g+1)};
  end

endmodule

// File: rtl/vsti_min_sel.sv
module vsti_min_sel #(
  parameter int N_ENT = 5,
  parameter int ID_W  = 6,
  parameter int KEY_W = 19
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_ENT-1:0]       ent_valid,
  input  logic [N_ENT*ID_W-1:0]  ent_id,
  input  logic [N_ENT*KEY_W-1:0] ent_key,
  output logic                   win_any,
  output logic [ID_W-1:0]        win_id,
  output logic [KEY_W-1:0]       win_key
);

  localparam int IDX_W = $clog2(N_ENT);

  logic [IDX_W-1:0] win_idx;

  always_comb begin
    win_any = 1'b0;
    win_key = '1;
    win_idx = '0;
    for (int e = 0; e < N_ENT; e++) begin
      if (ent_valid[e] && (!win_any || (ent_key[e*KEY_W +: KEY_W] < win_key))) begin
        win_any = 1'b1;
        win_key = ent_key[e*KEY_W +: KEY_W];
        win_idx = IDX_W'(e);
      end
    end
  end

  assign win_id = win_any ? ent_id[win_idx*ID_W +: ID_W] : '0;

  // R7
  none_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid == '0) |-> (!win_any && win_id == '0));

  for (genvar g = 0; g < N_ENT; g++) begin : g_chk
    // R1
    win_not_worse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ent_valid[g] |-> (win_any && win_key <= ent_key[g*KEY_W +: KEY_W]));
  end

endmodule

// File: rtl/vsti_top.sv
module vsti_top #(
  parameter int N_CAND  = 4,
  parameter int ID_W    = 6,
  parameter int PRIO_W  = 9,
  parameter int EXT_ID  = 9,
  parameter bit OUT_REG = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CAND-1:0]        cand_valid,
  input  logic [N_CAND*ID_W-1:0]   cand_id,
  input  logic [N_CAND*PRIO_W-1:0] cand_prio,
  input  logic                     inj_en,
  input  logic [ID_W-1:0]          inj_id,
  input  logic [PRIO_W-1:0]        inj_prio,
  input  logic                     inj_late,
  input  logic                     prio_pass,
  output logic [ID_W-1:0]          top_id,
  output logic [7:0]               top_prio
);
  import vsti_pkg::*;

  localparam int N_ENT = N_CAND + 1;
  localparam int ORD_W = ID_W + 1;
  localparam int IDX_W = $clog2(N_ENT);
  localparam int KEY_W = PRIO_W + ORD_W + IDX_W;

  logic [N_ENT-1:0]       ent_valid;
  logic [N_ENT*ID_W-1:0]  ent_id;
  logic [N_ENT*KEY_W-1:0] ent_key;
  logic                   win_any;
  logic [ID_W-1:0]        win_id;
  logic [KEY_W-1:0]       win_key;
  logic [PRIO_W-1:0]      win_num;
  logic [ID_W-1:0]        raw_id;
  logic [RPT_W-1:0]       raw_prio;

  vsti_key_gen #(
    .N_CAND(N_CAND), .ID_W(ID_W), .PRIO_W(PRIO_W), .EXT_ID(EXT_ID)
  ) u_keys (
    .cand_valid(cand_valid), .cand_id(cand_id), .cand_prio(cand_prio),
    .inj_en(inj_en), .inj_id(inj_id), .inj_prio(inj_prio),
    .inj_late(inj_late),
    .ent_valid(ent_valid), .ent_id(ent_id), .ent_key(ent_key)
  );

  vsti_min_sel #(
    .N_ENT(N_ENT), .ID_W(ID_W), .KEY_W(KEY_W)
  ) u_sel (
    .clk(clk), .rst_n(rst_n),
    .ent_valid(ent_valid), .ent_id(ent_id), .ent_key(ent_key),
    .win_any(win_any), .win_id(win_id), .win_key(win_key)
  );

  assign win_num  = win_key[KEY_W-1 -: PRIO_W];
  assign raw_id   = win_id;
  assign raw_prio = report_prio(win_any, prio_pass, 16'(win_num));

  if (OUT_REG) begin : g_reg
    logic [ID_W-1:0]  q_id;
    logic [RPT_W-1:0] q_prio;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_id   <= '0;
        q_prio <= '0;
      end else begin
        q_id   <= raw_id;
        q_prio <= raw_prio;
      end
    end
    assign top_id   = q_id;
    assign top_prio = q_prio;

    // R11
    reg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (q_id == $past(raw_id) && q_prio == $past(raw_prio)));
  end else begin : g_comb
    assign top_id   = raw_id;
    assign top_prio = raw_prio;
  end

  // R8
  const_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_any && !prio_pass) |-> (raw_prio == RPT_W'(1)));

  // R10
  clamp_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_any && prio_pass && win_num > PRIO_W'(255)) |-> (raw_prio == '1));

  // R10
  clamp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_any && prio_pass && win_num == '0) |-> (raw_prio == '0));

  // R7
  empty_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_any |-> (raw_prio == '0 && raw_id == '0));

endmodule

// File: tb/vsti_top_test.sv
module vsti_top_test;
  localparam int CLK_P = 10;
  localparam int NC = 3;
  localparam int IW = 6;
  localparam int PW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic          cv [NC];
  logic [IW-1:0] cid [NC];
  logic [PW-1:0] cpr [NC];
  logic          vti, dpr, pass;
  logic [IW-1:0] iid;
  logic [PW-1:0] ipr;

  logic [NC-1:0]    p_valid;
  logic [NC*IW-1:0] p_id;
  logic [NC*PW-1:0] p_prio;
  always_comb begin
    for (int i = 0; i < NC; i++) begin
      p_valid[i]          = cv[i];
      p_id[i*IW +: IW]    = cid[i];
      p_prio[i*PW +: PW]  = cpr[i];
    end
  end

  logic [IW-1:0] c_id, r_id;
  logic [7:0]    c_prio, r_prio;

  vsti_top #(.N_CAND(NC), .ID_W(IW), .PRIO_W(PW), .EXT_ID(9), .OUT_REG(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .cand_valid(p_valid), .cand_id(p_id),
    .cand_prio(p_prio), .inj_en(vti), .inj_id(iid), .inj_prio(ipr),
    .inj_late(dpr), .prio_pass(pass), .top_id(c_id), .top_prio(c_prio));

  vsti_top #(.N_CAND(NC), .ID_W(IW), .PRIO_W(PW), .EXT_ID(9), .OUT_REG(1'b1)) uut_reg (
    .clk(clk), .rst_n(rst_n), .cand_valid(p_valid), .cand_id(p_id),
    .cand_prio(p_prio), .inj_en(vti), .inj_id(iid), .inj_prio(ipr),
    .inj_late(dpr), .prio_pass(pass), .top_id(r_id), .top_prio(r_prio));

  int checks = 0;
  int errors = 0;
  int exp_id, exp_prio, prev_id, prev_prio;
  bit prev_ok = 0;

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Entry 0 is the injected one, entries 1..NC the list.
  function automatic bit beats(input int a, input int b,
                               input int ids[NC+1], input int prs[NC+1]);
    bit special = (iid != 9);
    if (prs[a] != prs[b]) return prs[a] < prs[b];
    if (a == 0 && special) return !dpr;
    if (b == 0 && special) return dpr;
    if (ids[a] != ids[b]) begin
      if (ids[a] == 9) return 1;
      if (ids[b] == 9) return 0;
      return ids[a] < ids[b];
    end
    return a < b;
  endfunction

  task automatic model();
    int ids[NC+1];
    int prs[NC+1];
    bit ok[NC+1];
    int w = -1;
    ids[0] = iid; prs[0] = ipr; ok[0] = vti;
    for (int i = 0; i < NC; i++) begin
      ids[i+1] = cid[i]; prs[i+1] = cpr[i]; ok[i+1] = cv[i];
    end
    for (int a = 0; a <= NC; a++) begin
      bit all = ok[a];
      for (int b = 0; b <= NC; b++)
        if (all && ok[b] && b != a && !beats(a, b, ids, prs)) all = 0;
      if (all) w = a;
    end
    if (w < 0) begin
      exp_id = 0; exp_prio = 0;
    end else begin
      exp_id = ids[w];
      if (!pass)             exp_prio = 1;
      else if (prs[w] > 255) exp_prio = 255;
      else                   exp_prio = prs[w];
    end
  endtask

  task automatic edge_step();
    @(posedge clk); #1;
    if (prev_ok) begin
      check("R11 reg id", r_id, prev_id);
      check("R11 reg prio", r_prio, prev_prio);
    end
  endtask

  task automatic eval(input string tag);
    model();
    @(negedge clk);
    check({tag, " id"}, c_id, exp_id);
    check({tag, " prio"}, c_prio, exp_prio);
    prev_id = exp_id; prev_prio = exp_prio; prev_ok = 1;
  endtask

  task automatic clear();
    for (int i = 0; i < NC; i++) begin cv[i] = 0; cid[i] = 0; cpr[i] = 0; end
    vti = 0; iid = 0; ipr = 0; dpr = 0; pass = 1;
  endtask

  task automatic setc(input int i, input int id, input int pr);
    cv[i] = 1; cid[i] = IW'(id); cpr[i] = PW'(pr);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int idset[6] = '{9, 0, 3, 5, 63, 9};
    int prset[8] = '{0, 1, 2, 7, 255, 256, 300, 511};
    clear();
    setc(0, 3, 4);
    #(CLK_P * 3);
    check("R11 reset id", r_id, 0);
    check("R11 reset prio", r_prio, 0);
    @(negedge clk); rst_n = 1;

    edge_step(); clear(); setc(0, 3, 7); setc(1, 5, 2); eval("R1");
    edge_step(); clear(); setc(0, 5, 4); setc(1, 9, 4); setc(2, 3, 4); eval("R2 ext");
    edge_step(); clear(); setc(0, 5, 4); setc(1, 3, 4); eval("R2 asc");
    edge_step(); clear(); setc(0, 9, 4); vti = 1; iid = 5; ipr = 4; dpr = 0; eval("R3");
    edge_step(); clear(); setc(0, 9, 4); vti = 1; iid = 5; ipr = 4; dpr = 1; eval("R4");
    edge_step(); clear(); setc(0, 63, 4); vti = 1; iid = 5; ipr = 4; dpr = 1; eval("R4 hi");
    edge_step(); clear(); setc(0, 3, 4); vti = 1; iid = 9; ipr = 4; dpr = 1; eval("R5");
    edge_step(); clear(); setc(0, 3, 5); vti = 0; iid = 2; ipr = 0; eval("R6");
    edge_step(); clear(); eval("R7");
    edge_step(); clear(); iid = 4; ipr = 1; eval("R7 inj off");
    edge_step(); clear(); setc(0, 3, 200); pass = 0; eval("R8");
    edge_step(); clear(); setc(0, 3, 255); eval("R9 top");
    edge_step(); clear(); setc(0, 3, 1); eval("R9 low");
    edge_step(); clear(); setc(0, 3, 300); eval("R10 high");
    edge_step(); clear(); setc(0, 3, 0); eval("R10 zero");

    for (int n = 0; n < 4000; n++) begin
      string tag;
      edge_step();
      for (int i = 0; i < NC; i++) begin
        cv[i]  = 1'($urandom);
        cid[i] = IW'(idset[$urandom % 6]);
        cpr[i] = PW'(prset[$urandom % 8]);
      end
      vti  = 1'($urandom);
      iid  = IW'(idset[$urandom % 6]);
      ipr  = PW'(prset[$urandom % 8]);
      dpr  = 1'($urandom);
      pass = ($urandom % 4) != 0;
      tag = vti ? (iid != 9 ? (dpr ? "R4 sweep" : "R3 sweep") : "R5 sweep")
                : "R2 sweep";
      eval(tag);
    end
    edge_step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule